// File: doc/BRIEF.md
# Packet Page Allocator with Queues

This block manages the packet buffer of a small Ethernet controller. The buffer is split into a fixed number of pages, four by default, and a bitmask records which pages are in use. A new page is always taken from the lowest free slot. Three queues of page numbers sit beside the bitmask:

- a transmit queue of pages waiting to go out;
- a completion queue of pages whose transmission has finished;
- a receive queue of pages that hold incoming frames.

Software drives the block with a one-byte command. The top three bits of that byte select an operation, and the page the operation refers to comes from a separate page-number input. The receive side asks for pages through its own request line and gets the grant in the same cycle. The block returns the result of the last transmit allocation, the head of each readable queue and a count of pages in use. It also drives four status levels that interrupt logic elsewhere can mask and combine.

When a transmit allocation finds every page taken, it is held as pending. The first later cycle that releases any page completes it. Draining of the transmit queue starts while transmit is enabled and moves one entry per cycle. Once draining has begun it continues until the queue is empty.

Top module: `pkt_pool_mmu`

## Requirements
- R1: Every allocation takes the lowest-numbered free page. A transmit allocation that finds all pages in use stores result code 8'h80, and a receive request that finds all pages in use gets no grant.
- R2: Command byte bits [7:5] select the operation: 0 none, 1 transmit allocate, 2 allocator reset, 3 receive pop, 4 receive pop and free, 5 free page, 6 transmit enqueue, 7 transmit flush. Operation 0 changes no state.
- R3: A transmit allocate first clears the allocation status. On success it stores the page number as the result and sets the allocation status. On failure it leaves 8'h80 pending, and the next cycle that frees any page completes the allocation.
- R4: A drained page is freed in the same step when auto-release is high. Otherwise it is appended to the completion queue, provided that queue is not full.
- R5: Draining starts only in a cycle where transmit is enabled and the transmit queue is not empty. It removes one entry per cycle and keeps going until the queue is empty, even if transmit enable drops.
- R6: The completion-queue head and the receive-queue head each read 8'h80 while their queue is empty. Otherwise they read the page number, zero-extended.
- R7: The transmit-empty status is high exactly when the transmit queue is empty. The transmit-done status is high exactly when the completion queue holds an entry.
- R8: A granted receive request sets the receive status. A receive pop leaves the status set if entries remain and clears it when the queue becomes empty.
- R9: An allocator reset frees all pages, empties all three queues, drops any pending allocation and sets the result to 8'h00.
- R10: An enqueue to a full transmit queue is ignored and leaves the queue unchanged.
- R11: The pages-in-use output equals the number of pages currently allocated.
- R12: A receive request is granted the lowest page still free after a transmit allocation in the same cycle, and the granted page is pushed onto the receive queue.
- R13: Operation 4 frees the page at the receive-queue head. Operation 7 empties the transmit and completion queues and leaves page ownership unchanged.
- R14: A completion-pop pulse removes the head of the completion queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte valid this cycle |
| cmd_byte | input | 8 | Command; bits [7:5] select the operation |
| pkt_num | input | PW | Page operated on by free and enqueue |
| auto_release | input | 1 | Free drained pages instead of queuing them |
| tx_enable | input | 1 | Permits draining of the transmit queue |
| rx_req | input | 1 | Receive side asks for a page |
| done_pop | input | 1 | Remove the completion-queue head |
| rx_grant | output | 1 | Receive request granted this cycle |
| rx_page | output | PW | Page granted to the receive side |
| alloc_result | output | 8 | Last transmit allocation result, 8'h80 on failure |
| done_head | output | 8 | Completion-queue head or 8'h80 |
| rx_head | output | 8 | Receive-queue head or 8'h80 |
| pages_in_use | output | CW | Count of allocated pages |
| stat_alloc | output | 1 | Allocation status |
| stat_tx_done | output | 1 | Completion queue not empty |
| stat_tx_empty | output | 1 | Transmit queue empty |
| stat_rcv | output | 1 | Receive status |

## Verification
The allocator is exercised in four regimes:

- Allocation runs until the pool is exhausted, then a single page is released while a transmit allocation is pending. This separates the lowest-free search from the retry path: the retried allocation must land on exactly the released page.
- The transmit queue is drained with auto-release both low and high. The completion queue and the in-use count must then diverge in the way each setting predicts.
- The transmit queue is filled beyond its depth and then drained. The drain must empty the queue after exactly four steps, which shows whether the fifth enqueue was dropped.
- A transmit allocation and a receive request arrive in the same cycle. This tests the ordering between the two page requesters.

// File: rtl/pkt_pool_pkg.sv
package pkt_pool_pkg;
  localparam logic [7:0] NO_PAGE = 8'h80;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_TX_ALLOC   = 3'd1,
    OP_MMU_RESET  = 3'd2,
    OP_RX_POP     = 3'd3,
    OP_RX_POPFREE = 3'd4,
    OP_FREE       = 3'd5,
    OP_TX_ENQ     = 3'd6,
    OP_TX_FLUSH   = 3'd7
  } mmu_op_e;
endpackage

// File: rtl/pkt_pool_queue.sv
// Circular queue of page numbers: push, pop and clear, with clear taking priority.
module pkt_pool_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] count_nxt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q, rd_d, wr_d;
  logic [CW-1:0] cnt_q;
  logic          pop_ok, push_ok, ptr_en;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    // a full queue accepts a push only when it also pops in this cycle
    push_ok = push && ((cnt_q != CW'(DEPTH)) || pop_ok);
    if (clear) begin
      count_nxt = '0;
      rd_d      = '0;
      wr_d      = '0;
    end else begin
      count_nxt = cnt_q + CW'(push_ok) - CW'(pop_ok);
      rd_d      = pop_ok  ? inc(rd_q) : rd_q;
      wr_d      = push_ok ? inc(wr_q) : wr_q;
    end
    ptr_en = clear || pop_ok || push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clear) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/pkt_pool_bitmap.sv
// Page ownership bitmask with two lowest-free requesters; port A is served before port B.
module pkt_pool_bitmap #(
  parameter int PAGES = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_all,
  input  logic [PAGES-1:0] free_vec,
  input  logic             req_a,
  input  logic             req_b,
  output logic             gnt_a,
  output logic [PW-1:0]    page_a,
  output logic             gnt_b,
  output logic [PW-1:0]    page_b,
  output logic [PAGES-1:0] used
);
  logic [PAGES-1:0] used_q, after_free, after_a, used_d;
  logic             found_a, found_b, upd;

  always_comb begin
    after_free = clear_all ? '0 : (used_q & ~free_vec);
    found_a = 1'b0;
    page_a  = '0;
    for (int i = PAGES-1; i >= 0; i--) begin
      if (!after_free[i]) begin
        found_a = 1'b1;
        page_a  = PW'(i);
      end
    end
    gnt_a   = req_a && found_a;
    after_a = after_free;
    for (int i = 0; i < PAGES; i++) begin
      if (gnt_a && (page_a == PW'(i))) after_a[i] = 1'b1;
    end
    found_b = 1'b0;
    page_b  = '0;
    for (int i = PAGES-1; i >= 0; i--) begin
      if (!after_a[i]) begin
        found_b = 1'b1;
        page_b  = PW'(i);
      end
    end
    gnt_b  = req_b && found_b;
    used_d = after_a;
    for (int i = 0; i < PAGES; i++) begin
      if (gnt_b && (page_b == PW'(i))) used_d[i] = 1'b1;
    end
    upd = clear_all || (|free_vec) || gnt_a || gnt_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   used_q <= '0;
    else if (upd) used_q <= used_d;
  end

  assign used = used_q;
endmodule

// File: rtl/pkt_pool_mmu.sv
module pkt_pool_mmu
  import pkt_pool_pkg::*;
#(
  parameter int PAGES = 4,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_byte,
  input  logic [PW-1:0] pkt_num,
  input  logic          auto_release,
  input  logic          tx_enable,
  input  logic          rx_req,
  input  logic          done_pop,
  output logic          rx_grant,
  output logic [PW-1:0] rx_page,
  output logic [7:0]    alloc_result,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [CW-1:0] pages_in_use,
  output logic          stat_alloc,
  output logic          stat_tx_done,
  output logic          stat_tx_empty,
  output logic          stat_rcv
);
  mmu_op_e          op;
  logic             is_alloc, is_rst, is_rxpop, is_rxfree, is_free, is_enq, is_flush;
  logic             step;
  logic [PAGES-1:0] free_vec, used;
  logic             req_a, req_b, gnt_a, gnt_b;
  logic [PW-1:0]    page_a, page_b;
  logic [PW-1:0]    tx_hd, dn_hd, rx_hd;
  logic [CW-1:0]    tx_cnt, tx_cnt_nxt, dn_cnt, dn_cnt_nxt, rx_cnt, rx_cnt_nxt;

  logic [7:0]       result_q, result_d;
  logic             pend_q, pend_d, st_alloc_q, st_alloc_d;
  logic             rcv_q, rcv_d, drain_q, drain_d, res_en;

  // command decode
  always_comb begin
    op        = mmu_op_e'(cmd_byte[7:5]);
    is_alloc  = cmd_we && (op == OP_TX_ALLOC);
    is_rst    = cmd_we && (op == OP_MMU_RESET);
    is_rxpop  = cmd_we && ((op == OP_RX_POP) || (op == OP_RX_POPFREE));
    is_rxfree = cmd_we && (op == OP_RX_POPFREE);
    is_free   = cmd_we && (op == OP_FREE);
    is_enq    = cmd_we && (op == OP_TX_ENQ);
    is_flush  = cmd_we && (op == OP_TX_FLUSH);
  end

  // release sources and requesters
  always_comb begin
    step     = (tx_cnt != '0) && (tx_enable || drain_q);
    free_vec = '0;
    for (int i = 0; i < PAGES; i++) begin
      if (step && auto_release && (tx_hd == PW'(i)))        free_vec[i] = 1'b1;
      if (is_free && (pkt_num == PW'(i)))                   free_vec[i] = 1'b1;
      if (is_rxfree && (rx_cnt != '0) && (rx_hd == PW'(i))) free_vec[i] = 1'b1;
    end
    req_a = is_alloc || (pend_q && (|free_vec) && !is_rst);
    req_b = rx_req && !is_rst;
  end

  pkt_pool_bitmap #(.PAGES(PAGES), .PW(PW)) u_map (
    .clk(clk), .rst_n(rst_n), .clear_all(is_rst), .free_vec(free_vec),
    .req_a(req_a), .req_b(req_b), .gnt_a(gnt_a), .page_a(page_a),
    .gnt_b(gnt_b), .page_b(page_b), .used(used)
  );

  pkt_pool_queue #(.DEPTH(PAGES), .W(PW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(is_flush || is_rst),
    .push(is_enq), .push_data(pkt_num), .pop(step),
    .head(tx_hd), .count(tx_cnt), .count_nxt(tx_cnt_nxt)
  );

  pkt_pool_queue #(.DEPTH(PAGES), .W(PW)) u_doneq (
    .clk(clk), .rst_n(rst_n), .clear(is_flush || is_rst),
    .push(step && !auto_release), .push_data(tx_hd), .pop(done_pop),
    .head(dn_hd), .count(dn_cnt), .count_nxt(dn_cnt_nxt)
  );

  pkt_pool_queue #(.DEPTH(PAGES), .W(PW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(is_rst),
    .push(gnt_b), .push_data(page_b), .pop(is_rxpop),
    .head(rx_hd), .count(rx_cnt), .count_nxt(rx_cnt_nxt)
  );

  // next state
  always_comb begin
    result_d   = result_q;
    pend_d     = pend_q;
    st_alloc_d = st_alloc_q;
    if (is_rst) begin
      result_d = 8'h00;
      pend_d   = 1'b0;
    end else if (req_a) begin
      result_d   = gnt_a ? 8'(page_a) : NO_PAGE;
      pend_d     = !gnt_a;
      st_alloc_d = gnt_a;
    end
    res_en = is_rst || req_a;

    if (gnt_b)         rcv_d = 1'b1;
    else if (is_rxpop) rcv_d = (rx_cnt > CW'(1));
    else               rcv_d = rcv_q;

    drain_d = (tx_enable || drain_q) && (tx_cnt_nxt != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q   <= 8'h00;
      pend_q     <= 1'b0;
      st_alloc_q <= 1'b0;
    end else if (res_en) begin
      result_q   <= result_d;
      pend_q     <= pend_d;
      st_alloc_q <= st_alloc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_q   <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      rcv_q   <= rcv_d;
      drain_q <= drain_d;
    end
  end

  always_comb begin
    pages_in_use = '0;
    for (int i = 0; i < PAGES; i++) pages_in_use = pages_in_use + CW'(used[i]);
  end

  assign rx_grant      = gnt_b;
  assign rx_page       = page_b;
  assign alloc_result  = result_q;
  assign done_head     = (dn_cnt == '0) ? NO_PAGE : 8'(dn_hd);
  assign rx_head       = (rx_cnt == '0) ? NO_PAGE : 8'(rx_hd);
  assign stat_alloc    = st_alloc_q;
  assign stat_tx_done  = (dn_cnt != '0);
  assign stat_tx_empty = (tx_cnt == '0);
  assign stat_rcv      = rcv_q;
endmodule

// File: rtl/pkt_pool_mmu_chk.sv
module pkt_pool_mmu_chk #(
  parameter int PAGES = 4,
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(PAGES+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_we,
  input logic [7:0]    cmd_byte,
  input logic          rx_grant,
  input logic [7:0]    alloc_result,
  input logic [7:0]    done_head,
  input logic [7:0]    rx_head,
  input logic [CW-1:0] pages_in_use,
  input logic          stat_alloc,
  input logic          stat_tx_done,
  input logic          stat_tx_empty,
  input logic          stat_rcv
);
  assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stat_tx_done == (done_head != 8'h80));

  assert_full_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pages_in_use == CW'(PAGES) && !cmd_we && stat_tx_empty) |-> !rx_grant);

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[7:5] == 3'd2) |=>
      (pages_in_use == '0 && alloc_result == 8'h00 && stat_tx_empty && rx_head == 8'h80));

  assert_alloc_success_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[7:5] == 3'd1 && pages_in_use < CW'(PAGES)) |=>
      (stat_alloc && alloc_result != 8'h80));

  assert_rcv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[7:5] == 3'd3 && rx_head == 8'h80 && !rx_grant) |=> !stat_rcv);

  assert_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_byte[7:5] == 3'd7) |=> (stat_tx_empty && !stat_tx_done));
endmodule

bind pkt_pool_mmu pkt_pool_mmu_chk #(.PAGES(PAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
  .rx_grant(rx_grant), .alloc_result(alloc_result), .done_head(done_head),
  .rx_head(rx_head), .pages_in_use(pages_in_use), .stat_alloc(stat_alloc),
  .stat_tx_done(stat_tx_done), .stat_tx_empty(stat_tx_empty), .stat_rcv(stat_rcv)
);

// File: tb/pkt_pool_mmu_bench.sv
`timescale 1ns/1ps
module pkt_pool_mmu_bench;
  localparam int PAGES = 4;
  localparam int PW = 2;
  localparam int CW = 3;
  localparam int NV = 32;

  logic clk = 1'b0;
  logic rst_n, cmd_we, auto_release, tx_enable, rx_req, done_pop;
  logic [7:0] cmd_byte;
  logic [PW-1:0] pkt_num;
  logic rx_grant, stat_alloc, stat_tx_done, stat_tx_empty, stat_rcv;
  logic [PW-1:0] rx_page;
  logic [7:0] alloc_result, done_head, rx_head;
  logic [CW-1:0] pages_in_use;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pkt_pool_mmu #(.PAGES(PAGES)) u_pkt_pool_mmu (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte), .pkt_num(pkt_num),
    .auto_release(auto_release), .tx_enable(tx_enable), .rx_req(rx_req), .done_pop(done_pop),
    .rx_grant(rx_grant), .rx_page(rx_page), .alloc_result(alloc_result),
    .done_head(done_head), .rx_head(rx_head), .pages_in_use(pages_in_use),
    .stat_alloc(stat_alloc), .stat_tx_done(stat_tx_done),
    .stat_tx_empty(stat_tx_empty), .stat_rcv(stat_rcv)
  );

  // row: we, cmd, pkt, auto, txen, rxreq, dpop | result, inuse, done, rx, status{alloc,txdone,txempty,rcv}, req
  function automatic logic [49:0] row(input logic we, input logic [7:0] cmd, input logic [1:0] pk,
      input logic au, input logic te, input logic rq, input logic dp,
      input logic [7:0] res, input logic [2:0] iu, input logic [7:0] dh, input logic [7:0] rh,
      input logic [3:0] st, input logic [3:0] rn);
    return {we, cmd, pk, au, te, rq, dp, res, iu, dh, rh, st, rn};
  endfunction

  localparam logic [49:0] VEC [NV] = '{
    row(1, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b0010, 2),  // R2 op 0 no effect
    row(1, 8'h20, 0, 0, 0, 0, 0, 8'h00, 1, 8'h80, 8'h80, 4'b1010, 1),  // R1 lowest page 0
    row(1, 8'h20, 0, 0, 0, 0, 0, 8'h01, 2, 8'h80, 8'h80, 4'b1010, 1),  // R1 page 1
    row(0, 8'h00, 0, 0, 0, 1, 0, 8'h01, 3, 8'h80, 8'h02, 4'b1011, 12), // R12 rx gets 2
    row(1, 8'h20, 0, 0, 0, 0, 0, 8'h03, 4, 8'h80, 8'h02, 4'b1011, 1),  // R1 page 3
    row(1, 8'h20, 0, 0, 0, 0, 0, 8'h80, 4, 8'h80, 8'h02, 4'b0011, 3),  // R3 fail pending
    row(0, 8'h00, 0, 0, 0, 1, 0, 8'h80, 4, 8'h80, 8'h02, 4'b0011, 1),  // R1 rx full
    row(1, 8'hA0, 1, 0, 0, 0, 0, 8'h01, 4, 8'h80, 8'h02, 4'b1011, 3),  // R3 retry on free
    row(1, 8'hC0, 0, 0, 0, 0, 0, 8'h01, 4, 8'h80, 8'h02, 4'b1001, 7),  // R7 txq busy
    row(1, 8'hC0, 3, 0, 0, 0, 0, 8'h01, 4, 8'h80, 8'h02, 4'b1001, 5),  // R5 no tx when off
    row(0, 8'h00, 0, 0, 1, 0, 0, 8'h01, 4, 8'h00, 8'h02, 4'b1101, 4),  // R4 to done queue
    row(0, 8'h00, 0, 0, 0, 0, 0, 8'h01, 4, 8'h00, 8'h02, 4'b1111, 5),  // R5 drain continues
    row(0, 8'h00, 0, 0, 0, 0, 1, 8'h01, 4, 8'h03, 8'h02, 4'b1111, 14), // R14 pop done
    row(1, 8'h60, 0, 0, 0, 0, 0, 8'h01, 4, 8'h03, 8'h80, 4'b1110, 8),  // R8 rx empty clears
    row(1, 8'h80, 0, 0, 0, 0, 0, 8'h01, 4, 8'h03, 8'h80, 4'b1110, 6),  // R6 pop empty no free
    row(1, 8'hA0, 2, 0, 0, 0, 0, 8'h01, 3, 8'h03, 8'h80, 4'b1110, 11), // R11 free page 2
    row(0, 8'h00, 0, 0, 0, 1, 0, 8'h01, 4, 8'h03, 8'h02, 4'b1111, 12), // R12 rx gets 2 again
    row(1, 8'h80, 0, 0, 0, 0, 0, 8'h01, 3, 8'h03, 8'h80, 4'b1110, 13), // R13 pop and free
    row(1, 8'hC0, 1, 1, 1, 0, 0, 8'h01, 3, 8'h03, 8'h80, 4'b1100, 5),  // R5 enqueue, no step yet
    row(0, 8'h00, 0, 1, 1, 0, 0, 8'h01, 2, 8'h03, 8'h80, 4'b1110, 4),  // R4 auto-release frees
    row(1, 8'hE0, 0, 0, 0, 0, 0, 8'h01, 2, 8'h80, 8'h80, 4'b1010, 13), // R13 flush keeps pages
    row(1, 8'h40, 0, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b1010, 9),  // R9 allocator reset
    row(1, 8'hC0, 0, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b1000, 10),
    row(1, 8'hC0, 1, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b1000, 10),
    row(1, 8'hC0, 2, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b1000, 10),
    row(1, 8'hC0, 3, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b1000, 10),
    row(1, 8'hC0, 0, 0, 0, 0, 0, 8'h00, 0, 8'h80, 8'h80, 4'b1000, 10), // R10 fifth ignored
    row(0, 8'h00, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, 8'h80, 4'b1100, 10),
    row(0, 8'h00, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, 8'h80, 4'b1100, 10),
    row(0, 8'h00, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, 8'h80, 4'b1100, 10),
    row(0, 8'h00, 0, 0, 1, 0, 0, 8'h00, 0, 8'h00, 8'h80, 4'b1110, 10), // R10 empty after four
    row(0, 8'h00, 0, 0, 0, 0, 0, 8'h00, 0, 8'h00, 8'h80, 4'b1110, 10)
  };

  task automatic idle();
    cmd_we = 0; cmd_byte = 8'h00; pkt_num = '0; auto_release = 0;
    tx_enable = 0; rx_req = 0; done_pop = 0;
  endtask

  task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] obs();
    return {alloc_result, pages_in_use, done_head, rx_head,
            stat_alloc, stat_tx_done, stat_tx_empty, stat_rcv};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, R7 and R6
    check("R7 reset", obs(), {8'h00, 3'd0, 8'h80, 8'h80, 4'b0010});

    for (int i = 0; i < NV; i++) begin
      {cmd_we, cmd_byte, pkt_num, auto_release, tx_enable, rx_req, done_pop} = VEC[i][49:35];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i][3:0], i), obs(), VEC[i][34:4]);
      idle();
    end

    // R12 tx allocate and rx request in one cycle
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    cmd_we = 1; cmd_byte = 8'h20; rx_req = 1;
    #1;
    check("R12 rx grant", {29'd0, rx_grant, 1'b0}, {29'd0, 1'b1, 1'b0});
    check("R12 rx page", {29'd0, rx_page}, 31'd1);
    @(posedge clk); @(negedge clk); idle();
    check("R12 after", obs(), {8'h00, 3'd2, 8'h80, 8'h01, 4'b1011});

    // R1 fill pool then rx request is refused
    cmd_we = 1; cmd_byte = 8'h20;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk); idle();
    check("R1 full result", {23'd0, alloc_result}, {23'd0, 8'h03});
    rx_req = 1; #1;
    check("R1 no grant when full", {30'd0, rx_grant}, 31'd0);
    @(posedge clk); @(negedge clk); idle();
    check("R11 in use four", {28'd0, pages_in_use}, 31'd4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule